// File: doc/BRIEF.md
# Three-port parallel I/O adapter

A memory-mapped parallel I/O peripheral with three byte-wide ports named A, B and C. It runs in plain input/output mode only. Port C splits into a lower and an upper nibble, and each nibble has its own direction. A single control register sets the direction of A, B, lower C and upper C independently of each other. Each port keeps an output latch that drives its pins. Bits configured as inputs are read from the pins through a two-stage synchronizer.

A bus write can carry one of several update operations: a plain store, or a masked set, clear, toggle or change. The block does the read-modify-write on the latch in a single clock edge, so no other access can split it. Writing the control register always clears every output latch to zero, even when the new direction equals the old one.

Top module: `tri_port_pio`

## Requirements
- R1: While `rst` is high, and after it is released with no write yet, every port is an input (all `pin_*_oe` low), every latch and every `pin_*_out` is 0, and reading offset 3 returns 0.
- R2: Offset 0 selects port A, offset 1 port B, offset 2 port C and offset 3 the control register. Reading offset 3 returns the four direction bits in bits 3:0 and zeros above them.
- R3: Control bit 0 makes port A an output, bit 1 port B, bit 2 the lower nibble of C (bits 3:0) and bit 3 the upper nibble of C (bits 7:4). A 1 means output. `pin_*_oe` follows these bits from the edge after the control write.
- R4: Any write to offset 3 sets all latches of all ports to 0 on the same edge, whatever the operation code and even when the direction setting is unchanged.
- R5: Reading a port returns the latch value for its output bits and the synchronized pin value for its input bits. A pin level present before edge k becomes readable after edge k+1.
- R6: Operation code 0 (store) loads `bus_wdata` into the addressed latch and ignores `bus_mask`.
- R7: Operation code 1 (set) drives to 1 the latch bits where the mask is 1 and leaves the other bits unchanged.
- R8: Operation code 2 (clear) drives to 0 the latch bits where the mask is 1 and leaves the other bits unchanged.
- R9: Operation code 3 (toggle) inverts the latch bits where the mask is 1 and leaves the other bits unchanged.
- R10: Operation code 4 (change) copies `bus_wdata` into the bit positions where the mask is 1 and keeps the old latch bits where the mask is 0.
- R11: A write to a port configured as input updates its latch, which shows on `pin_*_out`, but `pin_*_oe` stays low and reads keep returning the pin value.
- R12: Operation codes 5 to 7 to a port, and any cycle with `bus_wr` low, leave all latches unchanged.
- R13: Every operation completes at the clock edge where it is presented. An operation in the next cycle works on the updated latch, so back-to-back masked operations compose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_addr | input | 2 | Register offset |
| bus_op | input | 3 | Update operation code for port writes |
| bus_wdata | input | 8 | Write data |
| bus_mask | input | 8 | Bit mask for masked operations |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr` (combinational) |
| pin_a_in | input | 8 | Port A pin levels |
| pin_a_out | output | 8 | Port A latch value |
| pin_a_oe | output | 8 | Port A drive enables |
| pin_b_in | input | 8 | Port B pin levels |
| pin_b_out | output | 8 | Port B latch value |
| pin_b_oe | output | 8 | Port B drive enables |
| pin_c_in | input | 8 | Port C pin levels |
| pin_c_out | output | 8 | Port C latch value |
| pin_c_oe | output | 8 | Port C drive enables, one value per nibble |

## Verification
The properties assume that the bus presents at most one access per clock. They also assume that `bus_op`, `bus_addr` and the data stay steady around the sampling edge, and that a cycle with `bus_wr` low is a true idle that must not move any latch. The bench drives every bus and pin input only on the falling edge and returns `bus_wr` low after each access, except where it deliberately chains writes back to back. It samples pins and read data on the falling edge, after the rising edge that captured the access. The pin inputs also change only on falling edges, so the two-edge synchronizer latency is counted exactly.

// File: rtl/tpio_pkg.sv
package tpio_pkg;

    localparam int unsigned PORT_W    = 8;
    localparam int unsigned NIB_W     = PORT_W / 2;
    localparam int unsigned N_PORTS   = 3;
    localparam int unsigned SYNC_LEN  = 2;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned DIR_W     = 4;

    typedef enum logic [2:0] {
        OP_STORE  = 3'd0,
        OP_SET    = 3'd1,
        OP_CLEAR  = 3'd2,
        OP_TOGGLE = 3'd3,
        OP_CHANGE = 3'd4
    } port_op_e;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A   = 2'd0,
        SEL_B   = 2'd1,
        SEL_C   = 2'd2,
        SEL_CTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic c_hi;
        logic c_lo;
        logic b;
        logic a;
    } dir_cfg_t;

    function automatic logic [PORT_W-1:0] pick_bits(
        input logic [PORT_W-1:0] drive_en,
        input logic [PORT_W-1:0] latch_v,
        input logic [PORT_W-1:0] pin_v
    );
        return (latch_v & drive_en) | (pin_v & ~drive_en);
    endfunction

endpackage

// File: rtl/tpio_sync.sv
module tpio_sync #(
    parameter int unsigned W      = tpio_pkg::PORT_W,
    parameter int unsigned STAGES = tpio_pkg::SYNC_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tpio_latch.sv
module tpio_latch
    import tpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_all,
    input  logic         wr_en,
    input  port_op_e     op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_STORE:  nxt = wdata;
            OP_SET:    nxt = q | mask;
            OP_CLEAR:  nxt = q & ~mask;
            OP_TOGGLE: nxt = q ^ mask;
            OP_CHANGE: nxt = (q & ~mask) | (wdata & mask);
            default:   nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) q <= '0;
        else if (wr_en)     q <= nxt;
    end
endmodule

// File: rtl/tpio_ctrl.sv
module tpio_ctrl
    import tpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [DIR_W-1:0] ctl_wdata,
    output dir_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst)         cfg <= '0;
        else if (ctl_wr) cfg <= dir_cfg_t'(ctl_wdata);
    end
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
    import tpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_op,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      bus_mask,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_a_in,
    output logic [W-1:0]      pin_a_out,
    output logic [W-1:0]      pin_a_oe,
    input  logic [W-1:0]      pin_b_in,
    output logic [W-1:0]      pin_b_out,
    output logic [W-1:0]      pin_b_oe,
    input  logic [W-1:0]      pin_c_in,
    output logic [W-1:0]      pin_c_out,
    output logic [W-1:0]      pin_c_oe
);
    localparam int unsigned HALF = W / 2;

    reg_sel_e sel;
    dir_cfg_t cfg;
    logic     ctl_wr;

    logic [N_PORTS-1:0][W-1:0] pin_in_v;
    logic [N_PORTS-1:0][W-1:0] sync_v;
    logic [N_PORTS-1:0][W-1:0] latch_v;
    logic [N_PORTS-1:0][W-1:0] oe_v;
    logic [N_PORTS-1:0][W-1:0] view_v;

    assign sel    = reg_sel_e'(bus_addr);
    assign ctl_wr = bus_wr && (sel == SEL_CTL);

    tpio_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (bus_wdata[DIR_W-1:0]),
        .cfg       (cfg)
    );

    assign pin_in_v = {pin_c_in, pin_b_in, pin_a_in};
    assign oe_v[0]  = {W{cfg.a}};
    assign oe_v[1]  = {W{cfg.b}};
    assign oe_v[2]  = {{(W-HALF){cfg.c_hi}}, {HALF{cfg.c_lo}}};

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic port_wr;
        assign port_wr = bus_wr && (bus_addr == ADDR_W'(p));

        tpio_latch #(.W(W)) u_latch (
            .clk     (clk),
            .rst     (rst),
            .clr_all (ctl_wr),
            .wr_en   (port_wr),
            .op      (port_op_e'(bus_op)),
            .wdata   (bus_wdata),
            .mask    (bus_mask),
            .q       (latch_v[p])
        );

        tpio_sync #(.W(W), .STAGES(SYNC_LEN)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pin_in_v[p]),
            .q   (sync_v[p])
        );

        assign view_v[p] = pick_bits(oe_v[p], latch_v[p], sync_v[p]);
    end

    always_comb begin
        unique case (sel)
            SEL_A:   bus_rdata = view_v[0];
            SEL_B:   bus_rdata = view_v[1];
            SEL_C:   bus_rdata = view_v[2];
            default: bus_rdata = {{(W-DIR_W){1'b0}}, cfg};
        endcase
    end

    assign pin_a_out = latch_v[0];
    assign pin_b_out = latch_v[1];
    assign pin_c_out = latch_v[2];
    assign pin_a_oe  = oe_v[0];
    assign pin_b_oe  = oe_v[1];
    assign pin_c_oe  = oe_v[2];
endmodule

// File: rtl/tpio_checker.sv
module tpio_checker #(
    parameter int unsigned W = tpio_pkg::PORT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [2:0]   bus_op,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_mask,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pin_a_out,
    input logic [W-1:0] pin_a_oe,
    input logic [W-1:0] pin_b_out,
    input logic [W-1:0] pin_b_oe,
    input logic [W-1:0] pin_c_out,
    input logic [W-1:0] pin_c_oe
);
    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (pin_a_oe == '0 && pin_b_oe == '0 && pin_c_oe == '0 &&
                 pin_a_out == '0 && pin_b_out == '0 && pin_c_out == '0));

    // R4
    a_r4_ctl_write_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=>
        (pin_a_out == '0 && pin_b_out == '0 && pin_c_out == '0));

    // R3
    a_r3_dir_follows_ctl: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=>
        (pin_a_oe == {W{$past(bus_wdata[0])}} && pin_b_oe == {W{$past(bus_wdata[1])}}));

    // R7
    a_r7_set_port_b: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1 && bus_op == 3'd1) |=>
        (((pin_b_out & $past(bus_mask)) == $past(bus_mask)) &&
         ((pin_b_out & ~$past(bus_mask)) == ($past(pin_b_out) & ~$past(bus_mask)))));

    // R9
    a_r9_toggle_port_a: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && bus_op == 3'd3) |=>
        (pin_a_out == ($past(pin_a_out) ^ $past(bus_mask))));

    // R12
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(pin_a_out) && $stable(pin_b_out) && $stable(pin_c_out) &&
                     $stable(pin_a_oe) && $stable(pin_c_oe)));

    // R5
    a_r5_read_driven_port: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd1 && pin_b_oe == {W{1'b1}}) |-> (bus_rdata == pin_b_out));
endmodule

bind tri_port_pio tpio_checker u_chk (.*);

// File: tb/tb_tri_port_pio.sv
module tb_tri_port_pio;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [2:0]   bus_op = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_mask = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_a_in = '0, pin_b_in = '0, pin_c_in = '0;
    logic [W-1:0] pin_a_out, pin_a_oe, pin_b_out, pin_b_oe, pin_c_out, pin_c_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tri_port_pio dut (.*);

    typedef struct packed {
        logic [3:0]   req;
        logic [2:0]   op;
        logic [W-1:0] data;
        logic [W-1:0] mask;
        logic [W-1:0] expv;
    } vec_t;

    // Port B walk, starting from a cleared latch, all ports output.
    localparam vec_t VEC [0:11] = '{
        '{4'd6,  3'd0, 8'h3C, 8'h00, 8'h3C},  // R6 store, mask ignored
        '{4'd7,  3'd1, 8'hFF, 8'h81, 8'hBD},  // R7 set
        '{4'd8,  3'd2, 8'hFF, 8'h0C, 8'hB1},  // R8 clear
        '{4'd9,  3'd3, 8'h00, 8'hF0, 8'h41},  // R9 toggle
        '{4'd10, 3'd4, 8'hAA, 8'h0F, 8'h4A},  // R10 change
        '{4'd10, 3'd4, 8'h55, 8'h00, 8'h4A},  // R10 empty mask
        '{4'd7,  3'd1, 8'hFF, 8'h00, 8'h4A},  // R7 empty mask
        '{4'd9,  3'd3, 8'h00, 8'hFF, 8'hB5},  // R9 full mask
        '{4'd8,  3'd2, 8'h00, 8'hFF, 8'h00},  // R8 full mask
        '{4'd6,  3'd0, 8'hC3, 8'hFF, 8'hC3},  // R6
        '{4'd12, 3'd5, 8'hFF, 8'hFF, 8'hC3},  // R12 code 5
        '{4'd12, 3'd7, 8'h00, 8'hFF, 8'hC3}   // R12 code 7
    };

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [2:0] op,
                      input logic [W-1:0] d, input logic [W-1:0] m);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_op = op; bus_wdata = d; bus_mask = m;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", pin_a_oe | pin_b_oe | pin_c_oe, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1", pin_a_out | pin_b_out | pin_c_out, 8'h00);
        rd(2'd3, v); check("R1", v, 8'h00);

        // R3 / R2: all outputs
        wr(2'd3, 3'd0, 8'hFF, 8'h00);
        check("R3", pin_a_oe & pin_b_oe & pin_c_oe, 8'hFF);
        rd(2'd3, v); check("R2", v, 8'h0F);

        foreach (VEC[i]) begin
            wr(2'd1, VEC[i].op, VEC[i].data, VEC[i].mask);
            n_chk++;
            if (pin_b_out !== VEC[i].expv) begin
                n_fail++;
                $display("FAIL R%0d: vector %0d got %02h expected %02h",
                         VEC[i].req, i, pin_b_out, VEC[i].expv);
            end
            rd(2'd1, v); check("R5", v, VEC[i].expv);
        end
        check("R2", pin_a_out | pin_c_out, 8'h00);

        // R12 idle cycle with write fields present but bus_wr low
        @(negedge clk);
        bus_addr = 2'd1; bus_op = 3'd0; bus_wdata = 8'h00;
        @(negedge clk);
        check("R12", pin_b_out, 8'hC3);

        // R13 back-to-back: store 00, set 0F, toggle 3C -> 33
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_op = 3'd0; bus_wdata = 8'h00; bus_mask = 8'h00;
        @(negedge clk);
        bus_op = 3'd1; bus_mask = 8'h0F;
        @(negedge clk);
        bus_op = 3'd3; bus_mask = 8'h3C;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R13", pin_b_out, 8'h33);

        // R4: rewrite same configuration clears latches
        wr(2'd0, 3'd0, 8'hA5, 8'h00);
        wr(2'd2, 3'd0, 8'h5A, 8'h00);
        check("R6", pin_a_out, 8'hA5);
        wr(2'd3, 3'd6, 8'h0F, 8'h00);
        check("R4", pin_a_out | pin_b_out | pin_c_out, 8'h00);
        check("R4", pin_a_oe, 8'hFF);

        // R5 synchronizer latency on port A as input
        wr(2'd3, 3'd0, 8'h04, 8'h00);
        check("R3", pin_a_oe | pin_b_oe, 8'h00);
        check("R3", pin_c_oe, 8'h0F);
        pin_a_in = 8'h3C;
        pin_c_in = 8'hF0;
        @(negedge clk);
        rd(2'd0, v); check("R5", v, 8'h00);
        @(negedge clk);
        rd(2'd0, v); check("R5", v, 8'h3C);

        // R5 mixed nibble port C: lower nibble from latch, upper from pin
        wr(2'd2, 3'd0, 8'h5A, 8'h00);
        rd(2'd2, v); check("R5", v, 8'hFA);

        // R11 write to input port: latch updates, not driven, read shows pin
        wr(2'd0, 3'd0, 8'h77, 8'h00);
        check("R11", pin_a_out, 8'h77);
        check("R11", pin_a_oe, 8'h00);
        rd(2'd0, v); check("R11", v, 8'h3C);

        // R10 change on input port latch, R8 clear
        wr(2'd0, 3'd4, 8'h80, 8'hF0);
        check("R10", pin_a_out, 8'h87);
        wr(2'd0, 3'd2, 8'h00, 8'h07);
        check("R8", pin_a_out, 8'h80);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", pin_a_out | pin_c_out | pin_c_oe, 8'h00);
        rd(2'd3, v); check("R1", v, 8'h00);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule